// File: doc/BRIEF.md
# Serial Command Front End for a 32-Channel DAC

This block is the digital command interface of a multi-channel, 14-bit voltage DAC. A host sends 32-bit command words over a four-wire serial link: an active-low chip select, a serial clock and a data input. Each word carries an operation code, a channel or register address and a 16-bit data field. The block keeps an input register and an output register for every channel, plus a small configuration register. It also drives a serial data output that returns readback values or passes whole command words on to the next device in a chain.

The serial pins run in an asynchronous domain. They are brought into the system clock through synchronizers, and their edges are detected there. The `dsp_n` pin picks the framing style. When it is high, a word counts only if chip select brackets exactly 32 clock pulses. When it is low, chip select only starts a word, and the word completes on its 32nd clock. The converter values are presented as one flat vector of register contents, next to shutdown and glitch-suppression flags that the analog side consumes.

Top module: `sdac_cmd_if`

## Requirements
- R1: Words are shifted in MSB first on rising SCLK edges. Bits [31:29] are the operation, [28:23] the address, [22:16] are ignored and [15:0] are data. With `dsp_n` high, a word executes on the rise of `cs_n` only if exactly 32 rising edges occurred while `cs_n` was low; any other count leaves every register and the readback word unchanged.
- R2: With `dsp_n` low, a word starts on the fall of `cs_n` and executes on its 32nd rising SCLK edge, even if `cs_n` has already returned high.
- R3: For channel addresses 0..31, operation 001 writes the input register, 010 writes both the input and DAC registers, and 011 copies the input register into the DAC register. The stored 14-bit value is data bits [15:2]. Operations 000 and 110 change nothing.
- R4: Address 63 applies operations 001, 010 and 011 to all 32 channels at once.
- R5: Operations 100 (input register) and 101 (DAC register) read a channel. The 14-bit value, left-justified with two zero bits, replaces the data field of the word shifted out during the next frame. Either read at address 33 returns the configuration word.
- R6: Operation 001 at address 33 writes the configuration bits: 12 = single-device output, 11 = glitch suppression, 10 = output disable, 9 = shutdown. Bit 13 is the error flag and cannot be written. All configuration bits are 0 after reset.
- R7: The error flag (configuration bit 13) sets on any of these commands, and the command then has no other effect: a read (100 or 101) of address 63; an operation from 001 to 101 at a reserved address (32..62 except 33); or operation 010 or 011 at address 33.
- R8: A configuration read returns the error flag as it stood and then clears it. Operation 111 clears the error flag and sets every input and DAC register to 0; it leaves the other configuration bits as they are.
- R9: With the single-device bit low, the next frame shifts out the whole previous 32-bit word, with the data field replaced on reads. With it high, only the 16-bit data field is shifted out, followed by zeros.
- R10: While the output-disable bit is high, `dout_oe` is low and `dout` stays low.
- R11: `shutdown` follows configuration bit 9. Register writes and reads still work during shutdown, and `dac_flat` keeps the stored values.
- R12: `glitch_en` follows configuration bit 11.
- R13: `dout` changes only after falling SCLK edges, so it is stable across each rising edge of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| dsp_n | input | 1 | Framing select: low = word completes on 32nd clock, high = chip select must bracket the word |
| dout | output | 1 | Serial data out for readback and chaining |
| dout_oe | output | 1 | High while the serial output is enabled |
| shutdown | output | 1 | All converters powered down |
| glitch_en | output | 1 | Glitch suppression enable |
| dac_flat | output | 448 | DAC register of channel n at bits [14n+13:14n] |

## Verification
Each pin change takes two synchronizer stages and one edge-detect register to reach the logic. A register update therefore shows up about four system clocks after the rise of chip select (R1) or after the 32nd rising SCLK edge (R2). A new `dout` bit appears four clocks after a falling SCLK edge. The bench holds each SCLK level for six clocks and samples `dout` at the end of each level, so each bit is checked both before and after the rising edge. The reference model is compared with the outputs on every clock. These per-clock comparisons are switched off only while the last bit of a frame is clocked in, and switched back on once the model has applied that word and the design has had three half-periods to settle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned CMD_W  = 32;
  localparam int unsigned FLD_W  = 16;
  localparam int unsigned ADR_W  = 6;
  localparam int unsigned OP_LSB = 29;
  localparam int unsigned AD_LSB = 23;

  typedef enum logic [2:0] {
    OP_NOP     = 3'b000,
    OP_WR_IN   = 3'b001,
    OP_WR_BOTH = 3'b010,
    OP_LOAD    = 3'b011,
    OP_RD_IN   = 3'b100,
    OP_RD_DAC  = 3'b101,
    OP_IDLE    = 3'b110,
    OP_CLEAR   = 3'b111
  } op_e;

  localparam logic [ADR_W-1:0] ADR_CFG = 6'd33;
  localparam logic [ADR_W-1:0] ADR_ALL = 6'd63;

  localparam int unsigned B_ERR  = 13;
  localparam int unsigned B_SING = 12;
  localparam int unsigned B_GLT  = 11;
  localparam int unsigned B_DIS  = 10;
  localparam int unsigned B_SHDN = 9;

  typedef struct packed {
    logic err;
    logic single;
    logic glitch;
    logic dis;
    logic shdn;
  } cfg_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  input  logic dsp_n,
  output logic rst_n,
  output logic cs_low,
  output logic cs_fall,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic din_s,
  output logic dsp_n_s
);
  logic [STAGES-1:0] rs_q, cs_q, sck_q, din_q, dsp_q;
  logic              cs_p, sck_p;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      rs_q  <= '0;
      cs_q  <= '1;
      sck_q <= '0;
      din_q <= '0;
      dsp_q <= '1;
      cs_p  <= 1'b1;
      sck_p <= 1'b0;
    end else begin
      rs_q  <= {rs_q[STAGES-2:0], 1'b1};
      cs_q  <= {cs_q[STAGES-2:0], cs_n};
      sck_q <= {sck_q[STAGES-2:0], sclk};
      din_q <= {din_q[STAGES-2:0], din};
      dsp_q <= {dsp_q[STAGES-2:0], dsp_n};
      cs_p  <= cs_q[STAGES-1];
      sck_p <= sck_q[STAGES-1];
    end
  end

  assign rst_n    = rs_q[STAGES-1];
  assign cs_low   = ~cs_q[STAGES-1];
  assign cs_fall  = cs_p & ~cs_q[STAGES-1];
  assign cs_rise  = ~cs_p & cs_q[STAGES-1];
  assign sck_rise = ~sck_p & sck_q[STAGES-1];
  assign sck_fall = sck_p & ~sck_q[STAGES-1];
  assign din_s    = din_q[STAGES-1];
  assign dsp_n_s  = dsp_q[STAGES-1];
endmodule

// File: rtl/sdac_frame.sv
module sdac_frame
  import sdac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dsp_n,
  input  logic             cs_low,
  input  logic             cs_fall,
  input  logic             cs_rise,
  input  logic             sck_rise,
  input  logic             din_s,
  output logic             active,
  output logic             done,
  output logic [CMD_W-1:0] word
);
  localparam int unsigned CNT_W = $clog2(CMD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(CMD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(CMD_W + 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CMD_W-1:0] sr_q, sr_n;
  logic             act_q, act_n, done_q, done_n, shift_ok;

  always_comb begin
    act_n    = act_q;
    cnt_n    = cnt_q;
    sr_n     = sr_q;
    done_n   = 1'b0;
    shift_ok = act_q & sck_rise & (~dsp_n | cs_low);
    if (cs_fall) begin
      act_n = 1'b1;
      cnt_n = '0;
    end else begin
      if (shift_ok) begin
        sr_n = {sr_q[CMD_W-2:0], din_s};
        if (cnt_q != CNT_OVER) cnt_n = cnt_q + 1'b1;
        if (!dsp_n && cnt_q == CNT_LAST) begin
          done_n = 1'b1;
          act_n  = 1'b0;
        end
      end
      if (dsp_n && cs_rise && act_q) begin
        act_n  = 1'b0;
        done_n = (cnt_q == CNT_FULL);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      done_q <= done_n;
      if (shift_ok) sr_q <= sr_n;
    end
  end

  assign active = act_q;
  assign done   = done_q;
  assign word   = sr_q;

  assert_exact_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> cnt_q == CNT_FULL);
  assert_frame_starts_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> cnt_q == '0);
  assert_cs_ignored_in_dsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dsp_n && act_q && !sck_rise && !cs_fall) |=> act_q);
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int unsigned NUM_CH = 32,
  parameter int unsigned DW     = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done,
  input  logic [CMD_W-1:0]     word,
  output cfg_t                 cfg,
  output logic [CMD_W-1:0]     out_load,
  output logic [NUM_CH*DW-1:0] dac_flat
);
  localparam int unsigned PAD = FLD_W - DW;

  logic [DW-1:0]    in_q [NUM_CH];
  logic [DW-1:0]    in_n [NUM_CH];
  logic [DW-1:0]    dac_q [NUM_CH];
  logic [DW-1:0]    dac_n [NUM_CH];
  cfg_t             cfg_q, cfg_n;
  op_e              op;
  logic [ADR_W-1:0] addr;
  logic [FLD_W-1:0] dat, rd_val, cfg_word, fld;
  logic [DW-1:0]    val;
  logic             is_cfg, is_all, is_rsv, is_rd, is_acc, bad, rd_hit;

  assign op     = op_e'(word[OP_LSB +: 3]);
  assign addr   = word[AD_LSB +: ADR_W];
  assign dat    = word[FLD_W-1:0];
  assign val    = dat[FLD_W-1 -: DW];
  assign is_cfg = (addr == ADR_CFG);
  assign is_all = (addr == ADR_ALL);
  assign is_rsv = (addr >= ADR_W'(NUM_CH)) & ~is_cfg & ~is_all;
  assign is_rd  = op inside {OP_RD_IN, OP_RD_DAC};
  assign is_acc = op inside {OP_WR_IN, OP_WR_BOTH, OP_LOAD, OP_RD_IN, OP_RD_DAC};
  assign bad    = is_acc & (is_rsv | (is_all & is_rd) |
                  (is_cfg & (op inside {OP_WR_BOTH, OP_LOAD})));

  always_comb begin
    cfg_word         = '0;
    cfg_word[B_ERR]  = cfg_q.err;
    cfg_word[B_SING] = cfg_q.single;
    cfg_word[B_GLT]  = cfg_q.glitch;
    cfg_word[B_DIS]  = cfg_q.dis;
    cfg_word[B_SHDN] = cfg_q.shdn;
  end

  always_comb begin
    in_n   = in_q;
    dac_n  = dac_q;
    cfg_n  = cfg_q;
    rd_hit = 1'b0;
    rd_val = '0;
    if (op == OP_CLEAR) begin
      for (int i = 0; i < NUM_CH; i++) begin
        in_n[i]  = '0;
        dac_n[i] = '0;
      end
      cfg_n.err = 1'b0;
    end else if (bad) begin
      cfg_n.err = 1'b1;
    end else if (is_acc && is_cfg) begin
      if (op == OP_WR_IN) begin
        cfg_n.single = dat[B_SING];
        cfg_n.glitch = dat[B_GLT];
        cfg_n.dis    = dat[B_DIS];
        cfg_n.shdn   = dat[B_SHDN];
      end else begin
        rd_hit    = 1'b1;
        rd_val    = cfg_word;
        cfg_n.err = 1'b0;
      end
    end else if (is_acc) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (is_all || addr == ADR_W'(i)) begin
          case (op)
            OP_WR_IN:   in_n[i] = val;
            OP_WR_BOTH: begin
              in_n[i]  = val;
              dac_n[i] = val;
            end
            OP_LOAD:    dac_n[i] = in_q[i];
            OP_RD_IN:   begin
              rd_hit = 1'b1;
              rd_val = FLD_W'(in_q[i]) << PAD;
            end
            OP_RD_DAC:  begin
              rd_hit = 1'b1;
              rd_val = FLD_W'(dac_q[i]) << PAD;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign fld      = rd_hit ? rd_val : dat;
  assign out_load = cfg_q.single ? {fld, {FLD_W{1'b0}}} : {word[CMD_W-1:FLD_W], fld};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        in_q[i]  <= '0;
        dac_q[i] <= '0;
      end
      cfg_q <= '0;
    end else if (done) begin
      in_q  <= in_n;
      dac_q <= dac_n;
      cfg_q <= cfg_n;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
    assign dac_flat[g*DW +: DW] = dac_q[g];
  end

  assign cfg = cfg_q;

  assert_err_readonly_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_WR_IN && is_cfg) |=> cfg_q.err == $past(cfg_q.err));
  assert_clear_drops_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_CLEAR) |=> !cfg_q.err);
  assert_dac_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(dac_flat));
endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
  import sdac_pkg::*;
#(
  parameter int unsigned NUM_CH      = 32,
  parameter int unsigned DW          = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 din,
  input  logic                 dsp_n,
  output logic                 dout,
  output logic                 dout_oe,
  output logic                 shutdown,
  output logic                 glitch_en,
  output logic [NUM_CH*DW-1:0] dac_flat
);
  localparam int unsigned FC_W = $clog2(CMD_W + 1);
  localparam logic [FC_W-1:0] FC_END = FC_W'(CMD_W);

  logic             rst_s, cs_low, cs_fall, cs_rise, sck_rise, sck_fall, din_s, dsp_s;
  logic             active, done;
  logic [CMD_W-1:0] word, out_load, ow_q, ow_n, ow_shift;
  logic [FC_W-1:0]  fc_q, fc_n;
  logic             dout_q, dout_n;
  cfg_t             cfg;

  sdac_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n_in(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dsp_n(dsp_n),
    .rst_n(rst_s), .cs_low(cs_low), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .din_s(din_s), .dsp_n_s(dsp_s)
  );

  sdac_frame i_frame (
    .clk(clk), .rst_n(rst_s), .dsp_n(dsp_s), .cs_low(cs_low), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .sck_rise(sck_rise), .din_s(din_s),
    .active(active), .done(done), .word(word)
  );

  sdac_regs #(.NUM_CH(NUM_CH), .DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_s), .done(done), .word(word),
    .cfg(cfg), .out_load(out_load), .dac_flat(dac_flat)
  );

  always_comb begin
    fc_n = fc_q;
    if (cs_fall) fc_n = '0;
    else if (sck_fall && active && fc_q != FC_END) fc_n = fc_q + 1'b1;
    ow_n     = done ? out_load : ow_q;
    ow_shift = ow_q << fc_q;
    dout_n   = ~cfg.dis & ow_shift[CMD_W-1];
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      fc_q   <= '0;
      ow_q   <= '0;
      dout_q <= 1'b0;
    end else begin
      fc_q   <= fc_n;
      dout_q <= dout_n;
      if (done) ow_q <= ow_n;
    end
  end

  assign dout      = dout_q;
  assign dout_oe   = ~cfg.dis;
  assign shutdown  = cfg.shdn;
  assign glitch_en = cfg.glitch;

  assert_dout_quiet_R10: assert property (@(posedge clk) disable iff (!rst_s)
    cfg.dis |=> !dout_q);
  assert_dout_on_fall_R13: assert property (@(posedge clk) disable iff (!rst_s)
    (sck_rise && active) |=> $stable(dout_q));
endmodule

// File: tb/test_sdac_cmd_if.sv
module test_sdac_cmd_if;
  localparam int NCH = 32;
  localparam int W   = 14;
  localparam int H   = 6;

  logic clk, rst_n, cs_n, sclk, din, dsp_n;
  logic dout, dout_oe, shutdown, glitch_en;
  logic [NCH*W-1:0] dac_flat;

  sdac_cmd_if i_sdac_cmd_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din), .dsp_n(dsp_n),
    .dout(dout), .dout_oe(dout_oe), .shutdown(shutdown), .glitch_en(glitch_en),
    .dac_flat(dac_flat)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int    n_chk = 0, n_fail = 0;
  bit    cmp_en = 0, finished = 0;
  string cur_req = "R6";

  logic [W-1:0] m_in  [NCH];
  logic [W-1:0] m_dac [NCH];
  bit           m_err, m_sing, m_glt, m_dis, m_shdn;
  logic [31:0]  m_out;

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", cur_req, msg);
    end
  endtask

  function automatic logic [31:0] cmd(input logic [2:0] op, input logic [5:0] a,
                                      input logic [15:0] d);
    return {op, a, 7'h2A, d};
  endfunction

  function automatic logic [15:0] cfg_val();
    return 16'(m_err) << 13 | 16'(m_sing) << 12 | 16'(m_glt) << 11 |
           16'(m_dis) << 10 | 16'(m_shdn) << 9;
  endfunction

  task automatic apply(input logic [31:0] w);
    int          op = int'(w[31:29]);
    int          a  = int'(w[28:23]);
    logic [15:0] d  = w[15:0];
    logic [15:0] lo = d;
    bit          sg = m_sing;
    if (op == 7) begin
      for (int c = 0; c < NCH; c++) begin m_in[c] = 0; m_dac[c] = 0; end
      m_err = 0;
    end else if (op >= 1 && op <= 5) begin
      if ((a >= 32 && a != 33 && a != 63) || (a == 63 && op >= 4) ||
          (a == 33 && (op == 2 || op == 3))) begin
        m_err = 1;
      end else if (a == 33) begin
        if (op == 1) begin
          m_sing = d[12]; m_glt = d[11]; m_dis = d[10]; m_shdn = d[9];
        end else begin
          lo = cfg_val();
          m_err = 0;
        end
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (a == 63 || a == c) begin
            if (op == 1 || op == 2) m_in[c] = d / 4;
            if (op == 2) m_dac[c] = d / 4;
            if (op == 3) m_dac[c] = m_in[c];
            if (op == 4) lo = 16'(m_in[c]) * 4;
            if (op == 5) lo = 16'(m_dac[c]) * 4;
          end
        end
      end
    end
    m_out = sg ? {lo, 16'h0} : {w[31:16], lo};
  endtask

  always @(negedge clk) begin
    if (cmp_en) begin
      logic [NCH*W-1:0] e;
      for (int c = 0; c < NCH; c++) e[c*W +: W] = m_dac[c];
      check(dac_flat === e, $sformatf("dac_flat act=%h exp=%h", dac_flat, e));
      check(shutdown === m_shdn, $sformatf("shutdown act=%b exp=%b", shutdown, m_shdn));
      check(glitch_en === m_glt, $sformatf("glitch_en act=%b exp=%b", glitch_en, m_glt));
      check(dout_oe === !m_dis, $sformatf("dout_oe act=%b exp=%b", dout_oe, !m_dis));
    end
  end

  task automatic xfer(input logic [31:0] w, input int nbits, input bit dsp, input int cs_bits);
    logic [31:0] ga = '0, gb = '0, ex;
    int nb = (nbits < 32) ? nbits : 32;
    dsp_n = !dsp;
    repeat (4) @(negedge clk);
    ex = m_dis ? 32'h0 : m_out;
    cs_n = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 32) ? w[31-i] : 1'b0;
      if (i == nbits - 1) cmp_en = 0;
      repeat (H) @(negedge clk);
      if (i < 32) ga[31-i] = dout;
      sclk = 1;
      repeat (H) @(negedge clk);
      if (i < 32) gb[31-i] = dout;
      sclk = 0;
      if (dsp && i + 1 == cs_bits) cs_n = 1;
    end
    repeat (H) @(negedge clk);
    cs_n = 1;
    repeat (3 * H) @(negedge clk);
    begin
      logic [31:0] ma = ~(32'hFFFF_FFFF >> nb);
      logic [31:0] mb = ~(32'hFFFF_FFFF >> (nb - 1));
      check((ga & ma) === (ex & ma),
            $sformatf("dout before rise act=%h exp=%h", ga & ma, ex & ma));
      check((gb & mb) === (ex & mb),
            $sformatf("R13 dout after rise act=%h exp=%h", gb & mb, ex & mb));
    end
    if (nbits == 32) apply(w);
    cmp_en = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cs_n = 1; sclk = 0; din = 0; dsp_n = 1;
    for (int c = 0; c < NCH; c++) begin m_in[c] = 0; m_dac[c] = 0; end
    m_err = 0; m_sing = 0; m_glt = 0; m_dis = 0; m_shdn = 0; m_out = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (6) @(negedge clk);
    cur_req = "R6";
    check(dout === 1'b0, $sformatf("reset dout act=%b exp=0", dout));
    cmp_en = 1;
    xfer(cmd(3'b100, 6'd33, 16'h0), 32, 0, 0);
    xfer(cmd(3'b001, 6'd33, 16'h2000), 32, 0, 0);
    xfer(cmd(3'b101, 6'd33, 16'h0), 32, 0, 0);
    cur_req = "R3";
    xfer(cmd(3'b001, 6'd5, 16'hABCD), 32, 0, 0);
    cur_req = "R5";
    xfer(cmd(3'b100, 6'd5, 16'hFFFF), 32, 0, 0);
    cur_req = "R3";
    xfer(cmd(3'b010, 6'd31, 16'h7FFC), 32, 0, 0);
    xfer(cmd(3'b011, 6'd5, 16'h0), 32, 0, 0);
    xfer(cmd(3'b110, 6'd5, 16'h1234), 32, 0, 0);
    cur_req = "R5";
    xfer(cmd(3'b101, 6'd5, 16'h0), 32, 0, 0);
    xfer(cmd(3'b101, 6'd31, 16'h0), 32, 0, 0);
    cur_req = "R4";
    xfer(cmd(3'b010, 6'd63, 16'h5554), 32, 0, 0);
    xfer(cmd(3'b001, 6'd63, 16'h1111), 32, 0, 0);
    xfer(cmd(3'b011, 6'd63, 16'h0), 32, 0, 0);
    cur_req = "R7";
    xfer(cmd(3'b100, 6'd63, 16'h0), 32, 0, 0);
    cur_req = "R8";
    xfer(cmd(3'b100, 6'd33, 16'h0), 32, 0, 0);
    xfer(cmd(3'b101, 6'd33, 16'h0), 32, 0, 0);
    cur_req = "R7";
    xfer(cmd(3'b001, 6'd40, 16'h8888), 32, 0, 0);
    xfer(cmd(3'b100, 6'd33, 16'h0), 32, 0, 0);
    xfer(cmd(3'b010, 6'd33, 16'h0E00), 32, 0, 0);
    xfer(cmd(3'b011, 6'd33, 16'h0), 32, 0, 0);
    xfer(cmd(3'b101, 6'd63, 16'h0), 32, 0, 0);
    cur_req = "R8";
    xfer(cmd(3'b111, 6'd0, 16'h0), 32, 0, 0);
    xfer(cmd(3'b100, 6'd33, 16'h0), 32, 0, 0);
    cur_req = "R1";
    xfer(cmd(3'b010, 6'd3, 16'h4444), 32, 0, 0);
    xfer(cmd(3'b010, 6'd3, 16'hFFFC), 31, 0, 0);
    xfer(cmd(3'b010, 6'd3, 16'hFFFC), 33, 0, 0);
    xfer(cmd(3'b010, 6'd3, 16'hFFFC), 5, 0, 0);
    xfer(cmd(3'b101, 6'd3, 16'h0), 32, 0, 0);
    cur_req = "R2";
    xfer(cmd(3'b010, 6'd7, 16'h3338), 32, 1, 3);
    xfer(cmd(3'b101, 6'd7, 16'h0), 32, 1, 0);
    cur_req = "R9";
    xfer(cmd(3'b001, 6'd33, 16'h1000), 32, 0, 0);
    xfer(cmd(3'b100, 6'd7, 16'h0), 32, 0, 0);
    xfer(cmd(3'b000, 6'd0, 16'h0), 32, 0, 0);
    xfer(cmd(3'b001, 6'd33, 16'h0000), 32, 0, 0);
    cur_req = "R12";
    xfer(cmd(3'b001, 6'd33, 16'h0800), 32, 0, 0);
    cur_req = "R11";
    xfer(cmd(3'b001, 6'd33, 16'h0200), 32, 0, 0);
    xfer(cmd(3'b010, 6'd9, 16'h2468), 32, 0, 0);
    xfer(cmd(3'b101, 6'd9, 16'h0), 32, 0, 0);
    xfer(cmd(3'b001, 6'd33, 16'h0000), 32, 0, 0);
    cur_req = "R10";
    xfer(cmd(3'b001, 6'd33, 16'h0400), 32, 0, 0);
    xfer(cmd(3'b100, 6'd9, 16'h0), 32, 0, 0);
    xfer(cmd(3'b001, 6'd33, 16'h0000), 32, 0, 0);
    xfer(cmd(3'b000, 6'd0, 16'h0), 32, 0, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule